// File: doc/BRIEF.md
# Embedded-Clock Frame Lock and Output Controller

This block sits behind a bit-rate sampler on a framed serial link. Each frame has twelve bits: a high start bit, ten data bits and a low end bit. The low-to-high step from one frame's end bit to the next frame's start bit is the embedded clock. A separate boundary finder reports where the start bit sits by pulsing `alignPulse`. Between pulses, the block keeps its own frame-position counter running.

At every frame boundary the block checks whether the embedded rising edge is present, and it keeps an active-low lock indicator from that history. A single missing edge drops lock. Two consecutive edges restore it. The block assembles each frame's ten data bits into a parallel word and produces a word strobe with a selectable capture edge. It raises a data-valid flag only from the second selected strobe edge after lock. A power control and an output-enable control turn the output drivers on and off. The drivers are modelled as enable flags, and power-down also clears all state.

Top module: `frame_lock_ctrl`

## Requirements
- R1: A frame is 12 bits: the start bit (1) first, then data bits d0..d9, then the end bit (0). When the next frame's start bit is sampled, `dataOut` is loaded with the previous frame's data, with d0 in bit 0.
- R2: An embedded edge is present when the bit sampled with the frame-position counter at 0 is 1 and the bit before it is 0. `alignPulse` high marks the current bit as position 0. Without it, the counter wraps every 12 bits.
- R3: While locked, one frame boundary without an embedded edge drives `lockN` high. `lockN` then stays high for at least two further frames.
- R4: Lock (`lockN` low) is declared at the second consecutive frame boundary with an edge. A boundary without an edge restarts that count. The first boundary after reset or power-up is never counted.
- R5: `dataValid` is high only while locked. It rises on the second selected strobe edge after `lockN` falls, and it falls together with lock.
- R6: With sync frames (start, d0..d4 = 1, d5..d9 = 0, end) at the input, lock is declared within 42 frames.
- R7: With `outEn` low, `dataDrive` and `strobeDrive` are low and `lockDrive` stays high. Lock and validity timing continue unchanged, so data is still valid as soon as `outEn` returns high.
- R8: With `pwrOn` low, all three drive flags are low and all state is cleared. When `pwrOn` returns high, acquisition starts over from the unlocked state.
- R9: The selected strobe edge falls mid-frame: position 6 is the first position in the frame's second half. With `strobeRise` = 1, `strobeOut` is low for positions 0..5 and high for 6..11. With `strobeRise` = 0, the polarity is inverted.
- R10: While unlocked and powered with `outEn` high, `dataDrive` stays high and the strobe keeps toggling, but `dataValid` stays low.
- R11: After reset, `lockN` = 1 and `dataValid` = 0. With `pwrOn` and `outEn` high, all drive flags are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrOn | input | 1 | Low = power down (clear state, all drivers off) |
| outEn | input | 1 | Enables the data and strobe drivers |
| strobeRise | input | 1 | 1 = capture on the rising strobe edge, 0 = falling |
| serBit | input | 1 | Sampled serial bit |
| alignPulse | input | 1 | Boundary finder: the current bit is a start bit |
| dataOut | output | 10 | Parallel data word |
| dataDrive | output | 1 | Driver enable for dataOut |
| dataValid | output | 1 | dataOut holds valid data |
| strobeOut | output | 1 | Word strobe |
| strobeDrive | output | 1 | Driver enable for strobeOut |
| lockN | output | 1 | Active-low lock indicator |
| lockDrive | output | 1 | Driver enable for lockN |

## Verification
A wrong edge count or a stale frame position shows at the ports within one or two frames. `lockN` then falls a frame early or late, or it fails to rise on the first missing edge. A validity counter that is off by one moves the `dataValid` rising edge by a whole frame, relative to the mid-frame strobe edge. State that survives power-down shows as lock reappearing after fewer than two fresh edges.

// File: rtl/lockctl_pkg.sv
package lockctl_pkg;
  typedef struct packed {
    logic clear;
    logic shiftEn;
    logic loadWord;
  } dpCtl_t;
endpackage

// File: rtl/flc_datapath.sv
module flc_datapath
  import lockctl_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic              serBit,
  output logic              edgeFound,
  output logic [DATA_W-1:0] word
);
  logic [DATA_W-1:0] shiftReg;
  logic              lastBit;

  assign edgeFound = serBit & ~lastBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      word     <= '0;
      lastBit  <= 1'b1;
    end else if (dpCtl.clear) begin
      shiftReg <= '0;
      word     <= '0;
      lastBit  <= 1'b1;
    end else begin
      lastBit <= serBit;
      if (dpCtl.shiftEn) shiftReg <= {serBit, shiftReg[DATA_W-1:1]};
      if (dpCtl.loadWord) word <= shiftReg;
    end
  end
endmodule

// File: rtl/flc_control.sv
module flc_control
  import lockctl_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int FRAME_W     = DATA_W + 2,
  parameter int ACQ_EDGES   = 2,
  parameter int VALID_EDGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   pwrOn,
  input  logic   alignPulse,
  input  logic   edgeFound,
  output dpCtl_t dpCtl,
  output logic   locked,
  output logic   dataValid,
  output logic   rawPhase
);
  localparam int POS_W = $clog2(FRAME_W);
  localparam int HALF  = FRAME_W / 2;
  localparam int ACQ_W = $clog2(ACQ_EDGES + 1);
  localparam int VAL_W = $clog2(VALID_EDGES + 1);

  logic [POS_W-1:0] bitPos, curPos;
  logic [ACQ_W-1:0] goodCnt;
  logic [VAL_W-1:0] validCnt;
  logic             frameTick, midTick;

  assign curPos    = alignPulse ? '0 : bitPos;
  assign frameTick = (curPos == '0);
  assign midTick   = (curPos == POS_W'(HALF - 1));

  assign dpCtl.clear    = ~pwrOn;
  assign dpCtl.loadWord = frameTick;
  assign dpCtl.shiftEn  = (curPos >= POS_W'(1)) && (curPos <= POS_W'(DATA_W));

  assign rawPhase  = (bitPos >= POS_W'(HALF));
  assign dataValid = locked && (validCnt == VAL_W'(VALID_EDGES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitPos   <= '0;
      goodCnt  <= '0;
      locked   <= 1'b0;
      validCnt <= '0;
    end else if (!pwrOn) begin
      bitPos   <= '0;
      goodCnt  <= '0;
      locked   <= 1'b0;
      validCnt <= '0;
    end else begin
      bitPos <= (curPos == POS_W'(FRAME_W - 1)) ? '0 : curPos + POS_W'(1);
      if (frameTick) begin
        if (!edgeFound) begin
          locked  <= 1'b0;
          goodCnt <= '0;
        end else if (!locked) begin
          if (goodCnt == ACQ_W'(ACQ_EDGES - 1)) begin
            locked  <= 1'b1;
            goodCnt <= '0;
          end else begin
            goodCnt <= goodCnt + ACQ_W'(1);
          end
        end
      end
      if (!locked) validCnt <= '0;
      else if (midTick && validCnt != VAL_W'(VALID_EDGES)) validCnt <= validCnt + VAL_W'(1);
    end
  end
endmodule

// File: rtl/frame_lock_ctrl.sv
module frame_lock_ctrl
  import lockctl_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int ACQ_EDGES   = 2,
  parameter int VALID_EDGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrOn,
  input  logic              outEn,
  input  logic              strobeRise,
  input  logic              serBit,
  input  logic              alignPulse,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataDrive,
  output logic              dataValid,
  output logic              strobeOut,
  output logic              strobeDrive,
  output logic              lockN,
  output logic              lockDrive
);
  localparam int FRAME_W = DATA_W + 2;

  dpCtl_t dpCtl;
  logic   edgeFound, locked, rawPhase;

  flc_datapath #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .serBit(serBit),
    .edgeFound(edgeFound), .word(dataOut)
  );

  flc_control #(
    .DATA_W(DATA_W), .FRAME_W(FRAME_W),
    .ACQ_EDGES(ACQ_EDGES), .VALID_EDGES(VALID_EDGES)
  ) uCtl (
    .clk(clk), .rstN(rstN), .pwrOn(pwrOn), .alignPulse(alignPulse),
    .edgeFound(edgeFound), .dpCtl(dpCtl), .locked(locked),
    .dataValid(dataValid), .rawPhase(rawPhase)
  );

  assign lockN       = ~locked;
  assign lockDrive   = pwrOn;
  assign dataDrive   = pwrOn & outEn;
  assign strobeDrive = pwrOn & outEn;
  assign strobeOut   = strobeRise ? rawPhase : ~rawPhase;
endmodule

// File: rtl/frame_lock_ctrl_chk.sv
module frame_lock_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic pwrOn,
  input logic dataValid,
  input logic lockN
);
  assert_valid_needs_lock_R5: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> !lockN);

  assert_no_valid_at_lock_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockN) |-> !dataValid);

  assert_unlock_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockN) |=> lockN);

  assert_pd_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    !pwrOn |=> (lockN && !dataValid));

  assert_valid_waits_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataValid) |-> $past(!lockN));
endmodule

bind frame_lock_ctrl frame_lock_ctrl_chk uChk (
  .clk(clk), .rstN(rstN), .pwrOn(pwrOn), .dataValid(dataValid), .lockN(lockN)
);

// File: tb/tb_frame_lock_ctrl.sv
`timescale 1ns/1ps
module tb_frame_lock_ctrl;
  logic clk = 0, rstN = 0, pwrOn = 1, outEn = 1, strobeRise = 1, serBit = 0, alignPulse = 0;
  logic [9:0] dataOut;
  logic dataDrive, dataValid, strobeOut, strobeDrive, lockN, lockDrive;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  frame_lock_ctrl dut (
    .clk(clk), .rstN(rstN), .pwrOn(pwrOn), .outEn(outEn), .strobeRise(strobeRise),
    .serBit(serBit), .alignPulse(alignPulse), .dataOut(dataOut), .dataDrive(dataDrive),
    .dataValid(dataValid), .strobeOut(strobeOut), .strobeDrive(strobeDrive),
    .lockN(lockN), .lockDrive(lockDrive)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b, input logic al);
    serBit = b; alignPulse = al;
    @(posedge clk); #1;
    alignPulse = 0;
  endtask

  task automatic sendFrame(input logic [9:0] d, input logic goodStart);
    sendBit(goodStart, 1'b1);
    for (int i = 0; i < 10; i++) sendBit(d[i], 1'b0);
    sendBit(1'b0, 1'b0);
  endtask

  task automatic powerCycle();
    pwrOn = 0;
    @(posedge clk); #1;
    check("R8 lockDrive off", lockDrive, 0);
    check("R8 dataDrive off", dataDrive, 0);
    check("R8 strobeDrive off", strobeDrive, 0);
    @(posedge clk); #1;
    pwrOn = 1;
    check("R8 lockN after pd", lockN, 1);
  endtask

  task automatic testReset();
    check("R11 lockN", lockN, 1);
    check("R11 dataValid", dataValid, 0);
    check("R11 drives", {lockDrive, dataDrive, strobeDrive}, 3'b111);
  endtask

  task automatic testAcquire();
    powerCycle();
    sendFrame(10'h155, 1);
    sendFrame(10'h2AA, 1);
    check("R4 one edge unlocked", lockN, 1);
    check("R10 driven while unlocked", dataDrive, 1);
    check("R10 not valid", dataValid, 0);
    sendFrame(10'h3C5, 1);
    check("R4 locked after two edges", lockN, 0);
    check("R5 not valid after lock frame", dataValid, 0);
    sendBit(1, 1);
    for (int i = 0; i < 4; i++) sendBit(1'b0, 1'b0);
    check("R5 before 2nd strobe", dataValid, 0);
    sendBit(1'b0, 1'b0);
    check("R5 at 2nd strobe", dataValid, 1);
    for (int i = 0; i < 6; i++) sendBit(1'b0, 1'b0);
    check("R1 word of previous frame", dataOut, 10'h3C5);
    sendFrame(10'h00F, 1);
    check("R1 word after next", dataOut, 10'h000);
  endtask

  task automatic testLoss();
    sendFrame(10'h123, 0);
    check("R3 lost on missing edge", lockN, 1);
    check("R5 valid drops", dataValid, 0);
    sendFrame(10'h123, 1);
    check("R3 still unlocked", lockN, 1);
    sendFrame(10'h321, 1);
    check("R3 relock after two", lockN, 0);
  endtask

  task automatic testCountRestart();
    powerCycle();
    sendFrame(10'h001, 1);
    sendFrame(10'h002, 1);
    sendFrame(10'h003, 0);
    sendFrame(10'h004, 1);
    check("R4 count restarted", lockN, 1);
    sendFrame(10'h005, 1);
    check("R4 lock after restart", lockN, 0);
    check("R2 edge at wrapped position", lockN, 0);
  endtask

  task automatic testStrobe(input logic rise);
    strobeRise = rise;
    sendBit(1, 1);
    for (int i = 1; i < 5; i++) sendBit(1'b0, 1'b0);
    check("R9 first half", strobeOut, rise ? 0 : 1);
    sendBit(1'b0, 1'b0);
    check("R9 second half", strobeOut, rise ? 1 : 0);
    for (int i = 6; i < 12; i++) sendBit(1'b0, 1'b0);
    strobeRise = 1;
  endtask

  task automatic testOutEn();
    powerCycle();
    outEn = 0;
    for (int f = 0; f < 4; f++) sendFrame(10'h0F0, 1);
    check("R7 data drive off", dataDrive, 0);
    check("R7 strobe drive off", strobeDrive, 0);
    check("R7 lock drive on", lockDrive, 1);
    check("R7 lock tracked", lockN, 0);
    outEn = 1; #1;
    check("R7 valid on reenable", dataValid, 1);
  endtask

  task automatic testSync();
    int n = 0;
    powerCycle();
    while (lockN && n < 60) begin
      sendFrame(10'h01F, 1);
      n++;
    end
    check("R6 sync lock within 42", (n <= 42) ? 1 : 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rstN = 1;
    testReset();
    testAcquire();
    testLoss();
    testCountRestart();
    testStrobe(1'b1);
    testStrobe(1'b0);
    testOutEn();
    testSync();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule